// File: doc/BRIEF.md
# USB Node Functional State Controller

This block keeps the two-bit functional state of a full-speed USB device and moves it only along the legal paths of the node life cycle. A move needs two things at once: a line condition that has already been seen on the bus, latched as an event flag, and a matching state-change request from firmware. Firmware requests that do not match a legal move, or whose line condition has not been seen, are dropped and the state stays as it is.

The block has an idle timer. A prescaler turns clock cycles into milliseconds, and the timer raises the 3 ms and 5 ms suspend-detect events after that much uninterrupted bus idle. Six event flags stay set until firmware reads them through a read-to-clear strobe: bus reset seen, host resume seen, 3 ms idle, 5 ms idle, end-of-packet after a remote wake, and local wake. Firmware should issue its request before it clears the flags that justify the request. A hardware reset or a software reset forces the node into the reset state and clears all flags and the idle timer.

States: RESET (00), RESUME (01), OPER (10), SUSPEND (11). Transitions: any state to RESET on bus-reset flag plus reset request. RESET to OPER on operational request. OPER to SUSPEND on 3 ms flag plus suspend request. SUSPEND to RESUME (remote wake) on wake flag, 5 ms flag and resume request. SUSPEND to OPER on host-resume flag plus operational request. RESUME to OPER on EOP flag plus operational request.

Top module: `usb_node_state_ctrl`

## Requirements
- R1: When rst_n is low, or after any clock edge with sw_reset high, node_state is 00 (RESET) and evt_flags is all zero. sw_reset takes priority over every set and request.
- R2: State codes are RESET=00, RESUME=01, OPER=10, SUSPEND=11, and req_state uses the same codes. In RESET, a request of 10 moves the state to OPER at the next edge.
- R3: In OPER, a request of 11 moves the state to SUSPEND only while the 3 ms flag (evt_flags bit 2) is set. Without that flag the state stays OPER.
- R4: In SUSPEND, a request of 01 moves the state to RESUME only while both the wake flag (bit 5) and the 5 ms flag (bit 3) are set.
- R5: In SUSPEND, a request of 10 moves the state to OPER only while the host-resume flag (bit 1) is set.
- R6: In RESUME, a request of 10 moves the state to OPER only while the EOP flag (bit 4) is set. Without it the state stays RESUME.
- R7: From any state, a request of 00 moves the state to RESET only while the bus-reset flag (bit 0) is set. Without it the state is unchanged.
- R8: Any request not listed in R2 to R7, and any cycle with req_valid low, leaves node_state unchanged.
- R9: Bit 2 sets at the edge that completes 3*CLKS_PER_MS consecutive cycles with line_idle high, and not one edge earlier. Bit 3 does the same at 5*CLKS_PER_MS.
- R10: A cycle with line_idle low restarts the idle count from zero.
- R11: Bit 4 is set by line_eop only while the state is RESUME. Bit 5 is set by local_wake only while the state is SUSPEND. Bit 0 is set by line_reset and bit 1 by line_resume in any state.
- R12: evt_rd high clears all flags at the next edge. A flag whose set condition is true in the same cycle stays set. A request in the same cycle as evt_rd is judged on the flags as they were before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset |
| req_valid | input | 1 | Firmware state-change request strobe |
| req_state | input | 2 | Requested state code |
| line_idle | input | 1 | Bus is in the idle state this cycle |
| line_reset | input | 1 | Bus reset signalling detected |
| line_resume | input | 1 | Host resume signalling detected |
| line_eop | input | 1 | Valid end-of-packet detected |
| local_wake | input | 1 | Local wake-up event |
| evt_rd | input | 1 | Read-to-clear strobe for the event flags |
| node_state | output | 2 | Current functional state |
| evt_flags | output | 6 | Event flags: 0 bus reset, 1 host resume, 2 idle 3 ms, 3 idle 5 ms, 4 EOP after wake, 5 local wake |

## Verification
Two functions can fall in the same cycle: a line event sets a flag while firmware pulses the read-to-clear strobe. The bench drives line_resume and evt_rd in one cycle and expects bit 1 to stay set while the other bits clear. It also pulses evt_rd on the same cycle that the idle count is broken, and checks that a later request is judged on flags that are really gone. The idle thresholds are checked one edge before and exactly at the expected edge.

// File: rtl/usb_nfs_pkg.sv
package usb_nfs_pkg;

    typedef enum logic [1:0] {
        NS_RESET   = 2'b00,
        NS_RESUME  = 2'b01,
        NS_OPER    = 2'b10,
        NS_SUSPEND = 2'b11
    } node_state_e;

    localparam int NUM_EVT  = 6;
    localparam int EV_RST   = 0;
    localparam int EV_HRES  = 1;
    localparam int EV_SD3   = 2;
    localparam int EV_SD5   = 3;
    localparam int EV_EOP   = 4;
    localparam int EV_WAKE  = 5;

endpackage

// File: rtl/usb_nfs_idle_timer.sv
module usb_nfs_idle_timer #(
    parameter int CLKS_PER_MS = 48000,
    parameter int SHORT_MS    = 3,
    parameter int LONG_MS     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic line_idle,
    output logic hit_short,
    output logic hit_long
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam int MW = $clog2(LONG_MS + 1);
    localparam logic [PW-1:0] PRE_MAX  = PW'(CLKS_PER_MS - 1);
    localparam logic [MW-1:0] MS_SAT   = MW'(LONG_MS);
    localparam logic [MW-1:0] MS_SHORT = MW'(SHORT_MS - 1);
    localparam logic [MW-1:0] MS_LONG  = MW'(LONG_MS - 1);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] ms_q;
    logic          ms_tick;

    assign ms_tick   = line_idle && (pre_q == PRE_MAX) && (ms_q != MS_SAT);
    assign hit_short = ms_tick && (ms_q == MS_SHORT);
    assign hit_long  = ms_tick && (ms_q == MS_LONG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (clr || !line_idle) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (pre_q == PRE_MAX) begin
            pre_q <= '0;
            if (ms_q != MS_SAT) begin
                ms_q <= ms_q + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/usb_nfs_event_flags.sv
module usb_nfs_event_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rd_clr,
    input  logic [N-1:0] set_in,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (clr) begin
                flags[g] <= 1'b0;
            end else if (set_in[g]) begin
                flags[g] <= 1'b1;
            end else if (rd_clr) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usb_nfs_fsm.sv
module usb_nfs_fsm
    import usb_nfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               req_valid,
    input  logic [1:0]         req_state,
    input  logic [NUM_EVT-1:0] flags,
    output node_state_e        state
);
    node_state_e cur_q, nxt;
    node_state_e req;

    assign req = node_state_e'(req_state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= NS_RESET;
        end else if (sw_reset) begin
            cur_q <= NS_RESET;
        end else begin
            cur_q <= nxt;
        end
    end

    always_comb begin
        nxt = cur_q;
        if (req_valid) begin
            if (req == NS_RESET && flags[EV_RST]) begin
                nxt = NS_RESET;
            end else begin
                unique case (cur_q)
                    NS_RESET: begin
                        if (req == NS_OPER) nxt = NS_OPER;
                    end
                    NS_OPER: begin
                        if (req == NS_SUSPEND && flags[EV_SD3]) nxt = NS_SUSPEND;
                    end
                    NS_SUSPEND: begin
                        if (req == NS_RESUME && flags[EV_WAKE] && flags[EV_SD5])
                            nxt = NS_RESUME;
                        else if (req == NS_OPER && flags[EV_HRES])
                            nxt = NS_OPER;
                    end
                    NS_RESUME: begin
                        if (req == NS_OPER && flags[EV_EOP]) nxt = NS_OPER;
                    end
                    default: nxt = cur_q;
                endcase
            end
        end
    end

    always_comb begin
        state = cur_q;
    end

endmodule

// File: rtl/usb_node_state_ctrl.sv
module usb_node_state_ctrl
    import usb_nfs_pkg::*;
#(
    parameter int CLKS_PER_MS = 48000,
    parameter int SHORT_MS    = 3,
    parameter int LONG_MS     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_reset,
    input  logic       req_valid,
    input  logic [1:0] req_state,
    input  logic       line_idle,
    input  logic       line_reset,
    input  logic       line_resume,
    input  logic       line_eop,
    input  logic       local_wake,
    input  logic       evt_rd,
    output logic [1:0] node_state,
    output logic [5:0] evt_flags
);
    node_state_e        st;
    logic               hit_short, hit_long;
    logic [NUM_EVT-1:0] set_vec;
    logic [NUM_EVT-1:0] flags;

    usb_nfs_idle_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .SHORT_MS    (SHORT_MS),
        .LONG_MS     (LONG_MS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_reset),
        .line_idle (line_idle),
        .hit_short (hit_short),
        .hit_long  (hit_long)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[EV_RST]  = line_reset;
        set_vec[EV_HRES] = line_resume;
        set_vec[EV_SD3]  = hit_short;
        set_vec[EV_SD5]  = hit_long;
        set_vec[EV_EOP]  = line_eop && (st == NS_RESUME);
        set_vec[EV_WAKE] = local_wake && (st == NS_SUSPEND);
    end

    usb_nfs_event_flags #(
        .N (NUM_EVT)
    ) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sw_reset),
        .rd_clr (evt_rd),
        .set_in (set_vec),
        .flags  (flags)
    );

    usb_nfs_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .req_valid (req_valid),
        .req_state (req_state),
        .flags     (flags),
        .state     (st)
    );

    assign node_state = st;
    assign evt_flags  = flags;

endmodule

// File: rtl/usb_node_state_ctrl_chk.sv
module usb_node_state_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_reset,
    input logic       req_valid,
    input logic [1:0] req_state,
    input logic       line_idle,
    input logic       line_reset,
    input logic       evt_rd,
    input logic [1:0] node_state,
    input logic [5:0] evt_flags
);
    // R1
    sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (node_state == 2'b00 && evt_flags == 6'd0));

    // R2
    rst_to_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset && req_valid && req_state == 2'b10 && node_state == 2'b00)
        |=> node_state == 2'b10);

    // R3
    no_early_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset && req_valid && req_state == 2'b11 && node_state == 2'b10
         && !evt_flags[2]) |=> node_state == 2'b10);

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset && !req_valid) |=> $stable(node_state));

    // R9
    idle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[2]) |-> $past(line_idle));

    // R12
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !line_reset && !sw_reset) |=> !evt_flags[0]);

endmodule

bind usb_node_state_ctrl usb_node_state_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .req_valid  (req_valid),
    .req_state  (req_state),
    .line_idle  (line_idle),
    .line_reset (line_reset),
    .evt_rd     (evt_rd),
    .node_state (node_state),
    .evt_flags  (evt_flags)
);

// File: tb/test_usb_node_state_ctrl.sv
`timescale 1ns/1ps
module test_usb_node_state_ctrl;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_state = 2'b00;
    logic       line_idle = 1'b0;
    logic       line_reset = 1'b0;
    logic       line_resume = 1'b0;
    logic       line_eop = 1'b0;
    logic       local_wake = 1'b0;
    logic       evt_rd = 1'b0;
    logic [1:0] node_state;
    logic [5:0] evt_flags;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usb_node_state_ctrl #(.CLKS_PER_MS(P)) i_usb_node_state_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .req_valid(req_valid), .req_state(req_state),
        .line_idle(line_idle), .line_reset(line_reset),
        .line_resume(line_resume), .line_eop(line_eop),
        .local_wake(local_wake), .evt_rd(evt_rd),
        .node_state(node_state), .evt_flags(evt_flags)
    );

    // Row: rv, req[2], lrst, lres, leop, wake, rd, exp_state[2], exp_evt[6], req_no[4]
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 2'b10, 5'b00000, 2'b10, 6'b000000, 4'd2},  // R2 reset -> oper
        {1'b1, 2'b11, 5'b00000, 2'b10, 6'b000000, 4'd3},  // R3 suspend without 3 ms flag
        {1'b1, 2'b01, 5'b00000, 2'b10, 6'b000000, 4'd8},  // R8 illegal resume from oper
        {1'b1, 2'b00, 5'b00000, 2'b10, 6'b000000, 4'd7},  // R7 reset req without flag
        {1'b0, 2'b00, 5'b10000, 2'b10, 6'b000001, 4'd11}, // R11 bus reset flag
        {1'b1, 2'b00, 5'b00000, 2'b00, 6'b000001, 4'd7},  // R7 reset path
        {1'b0, 2'b00, 5'b00001, 2'b00, 6'b000000, 4'd12}, // R12 read clears
        {1'b0, 2'b00, 5'b01001, 2'b00, 6'b000010, 4'd12}, // R12 set wins over clear
        {1'b1, 2'b11, 5'b00000, 2'b00, 6'b000010, 4'd8},  // R8 illegal suspend from reset
        {1'b0, 2'b00, 5'b00100, 2'b00, 6'b000010, 4'd11}, // R11 eop ignored outside resume
        {1'b0, 2'b00, 5'b00010, 2'b00, 6'b000010, 4'd11}, // R11 wake ignored outside suspend
        {1'b1, 2'b10, 5'b00000, 2'b10, 6'b000010, 4'd2},  // R2 reset -> oper again
        {1'b0, 2'b00, 5'b00001, 2'b10, 6'b000000, 4'd12}  // R12 read clears
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic request(input logic [1:0] code);
        req_valid = 1'b1;
        req_state = code;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic idle_for(input int n);
        line_idle = 1'b1;
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1 state in reset", {6'd0, node_state}, 8'h00);
        check("R1 flags in reset", {2'd0, evt_flags}, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            req_valid   = VEC[i][19];
            req_state   = VEC[i][18:17];
            line_reset  = VEC[i][16];
            line_resume = VEC[i][15];
            line_eop    = VEC[i][14];
            local_wake  = VEC[i][13];
            evt_rd      = VEC[i][12];
            tick();
            req_valid = 1'b0; line_reset = 1'b0; line_resume = 1'b0;
            line_eop = 1'b0; local_wake = 1'b0; evt_rd = 1'b0;
            check($sformatf("R%0d row %0d state", VEC[i][3:0], i),
                  {6'd0, node_state}, {6'd0, VEC[i][11:10]});
            check($sformatf("R%0d row %0d flags", VEC[i][3:0], i),
                  {2'd0, evt_flags}, {2'd0, VEC[i][9:4]});
        end

        // R9 3 ms threshold, state OPER
        idle_for(3 * P - 1);
        check("R9 sd3 one edge early", {7'd0, evt_flags[2]}, 8'd0);
        tick();
        check("R9 sd3 at threshold", {7'd0, evt_flags[2]}, 8'd1);

        // R10 break restarts count (read on the breaking cycle)
        line_idle = 1'b0; evt_rd = 1'b1; tick(); evt_rd = 1'b0;
        idle_for(2 * P);
        line_idle = 1'b0; tick();
        idle_for(2 * P);
        check("R10 interrupted idle no sd3", {7'd0, evt_flags[2]}, 8'd0);
        idle_for(P);
        check("R10 sd3 after fresh 3 ms", {7'd0, evt_flags[2]}, 8'd1);
        idle_for(2 * P - 1);
        check("R9 sd5 one edge early", {7'd0, evt_flags[3]}, 8'd0);
        tick();
        check("R9 sd5 at threshold", {7'd0, evt_flags[3]}, 8'd1);
        line_idle = 1'b0;

        request(2'b11);
        check("R3 oper -> suspend", {6'd0, node_state}, 8'd3);
        request(2'b01);
        check("R4 resume without wake ignored", {6'd0, node_state}, 8'd3);
        local_wake = 1'b1; tick(); local_wake = 1'b0;
        check("R11 wake flag in suspend", {7'd0, evt_flags[5]}, 8'd1);
        request(2'b01);
        check("R4 suspend -> resume", {6'd0, node_state}, 8'd1);
        request(2'b10);
        check("R6 oper without eop ignored", {6'd0, node_state}, 8'd1);
        line_eop = 1'b1; tick(); line_eop = 1'b0;
        check("R11 eop flag in resume", {7'd0, evt_flags[4]}, 8'd1);
        request(2'b10);
        check("R6 resume -> oper", {6'd0, node_state}, 8'd2);

        evt_rd = 1'b1; tick(); evt_rd = 1'b0;
        idle_for(3 * P);
        line_idle = 1'b0;
        request(2'b11);
        check("R3 back to suspend", {6'd0, node_state}, 8'd3);
        request(2'b10);
        check("R5 oper without host resume ignored", {6'd0, node_state}, 8'd3);
        line_resume = 1'b1; tick(); line_resume = 1'b0;
        request(2'b10);
        check("R5 suspend -> oper", {6'd0, node_state}, 8'd2);

        sw_reset = 1'b1; line_reset = 1'b1; tick();
        sw_reset = 1'b0; line_reset = 1'b0;
        check("R1 sw reset state", {6'd0, node_state}, 8'd0);
        check("R1 sw reset flags", {2'd0, evt_flags}, 8'd0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule